// File: doc/BRIEF.md
# PHY Management Frame Controller

This block runs single read or write transactions to an external Ethernet PHY over the two-wire management bus. One wire is the management clock (MDC) and the other is bidirectional data (MDIO). Software first loads a 16-bit data register. It then writes one control word that carries the PHY register number, the PHY address, a direction flag, a start/busy flag and a clock-enable flag. That single write launches the whole transaction.

The controller then sends a standard clause-22 frame, MSB first. The frame is 32 preamble ones, the start pattern 01, an opcode, the 5-bit PHY address, the 5-bit register number, a 2-bit turnaround and 16 data bits. Software polls the busy flag in the control word until it reads 0. After a read, the data register then holds the value the PHY returned.

MDC comes from the system clock through a programmable divider. The divider input sets the half period in system clock cycles.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset, the control readback and the data readback are both 0, MDC is low and the MDIO output enable is low.
- R2: The control word layout is as follows. Bits [4:0] hold the register number and bits [12:8] hold the PHY address. Bit 13 is the write flag (1 = write, 0 = read), bit 14 is busy/start and bit 15 is the MDC enable. Bits [7:5] read as 0, and the readback returns the stored fields with the live busy state.
- R3: A control write with bit 14 set, made while the block is idle, starts a transaction. Busy then reads 1 for exactly 128*(clk_div+1) system clock cycles after the launching edge, and 0 afterwards.
- R4: A write frame presents these bits on MDIO, all with the output enable high, in order: 32 ones, 01, opcode 01, PHY address, register number, turnaround 10, and the data register value. Every bit is valid at a rising edge of MDC.
- R5: A read frame carries opcode 10. The output enable is low for the two turnaround bits and the 16 data bits. The PHY's MDIO value at the 16 data-bit rising edges is shifted in MSB first and is in the data register by the time busy reads 0.
- R6: MDC has a period of 2*(clk_div+1) system clock cycles while a transaction runs. MDIO changes only together with a falling edge of MDC.
- R7: When a transaction is launched with the MDC enable clear, MDC stays low and the transaction makes no progress, so busy stays 1 until reset.
- R8: Control writes while busy is 1 are ignored: the frame in progress and the stored fields are unchanged.
- R9: Data register writes while busy is 1 are ignored.
- R10: A control write with bit 14 clear, made while idle, updates the stored fields without starting a transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_div | input | DIV_W | MDC half period minus one, in system clock cycles |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 16 | Control word write value |
| ctl_rdata | output | 16 | Control word readback with live busy |
| data_wr | input | 1 | Data register write strobe |
| data_wdata | input | 16 | Data register write value |
| data_rdata | output | 16 | Data register readback |
| mdc | output | 1 | Management clock to the PHY |
| mdio_out | output | 1 | MDIO value driven when enabled |
| mdio_oe | output | 1 | MDIO output enable (0 = released) |
| mdio_in | input | 1 | MDIO value seen on the pin |

## Verification
The embedded assertions check the following on every cycle:
- MDIO moves only on an MDC falling edge.
- Busy clears only on an MDC falling edge.
- A launch raises busy, and busy holds until the sequencer reports completion.
- MDC stays low while the clock enable is off.
- While busy, control and data writes leave the stored state untouched.

Only the bench scenarios can show the rest:
- The exact bit order and content of write and read frames.
- The turnaround release.
- The captured read value.
- The total cycle count for several divider settings.
- That interfering writes in mid-frame leave both the frame and the readback intact.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int CTL_W      = 16;
  localparam int DATA_W     = 16;
  localparam int FRAME_LEN  = 64;
  localparam int PREAMBLE   = 32;
  localparam int TA_IDX     = 46;
  localparam int DATA_IDX   = 48;
  localparam int IDX_W      = $clog2(FRAME_LEN);

  // control word layout, MSB first
  typedef struct packed {
    logic       cken;   // 15
    logic       go;     // 14
    logic       wr;     // 13
    logic [4:0] phy;    // 12:8
    logic [2:0] rsv;    // 7:5
    logic [4:0] regn;   // 4:0
  } ctl_t;
endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             mdc,
  output logic             rise,
  output logic             fall
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             mdc_q, mdc_d;
  logic             tick;

  assign tick = run && (cnt_q == div);
  assign rise = tick && !mdc_q;
  assign fall = tick && mdc_q;
  assign mdc  = mdc_q;

  always_comb begin
    cnt_d = cnt_q;
    mdc_d = mdc_q;
    if (!run) begin
      cnt_d = '0;
      mdc_d = 1'b0;
    end else if (tick) begin
      cnt_d = '0;
      mdc_d = ~mdc_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  ctl_t              launch_word,
  input  logic [DATA_W-1:0] wdata,
  input  logic              busy,
  input  logic              rise,
  input  logic              fall,
  input  logic              mdio_in,
  output logic              mdio_out,
  output logic              mdio_oe,
  output logic              done,
  output logic [DATA_W-1:0] rdata
);
  localparam logic [IDX_W-1:0] LAST  = IDX_W'(FRAME_LEN - 1);
  localparam logic [IDX_W-1:0] TA_I  = IDX_W'(TA_IDX);
  localparam logic [IDX_W-1:0] DAT_I = IDX_W'(DATA_IDX);

  logic [IDX_W-1:0]     idx_q, idx_d;
  logic [FRAME_LEN-1:0] sh_q, sh_d;
  logic [DATA_W-1:0]    rx_q, rx_d;
  logic                 rd_q, rd_d;
  logic [FRAME_LEN-1:0] frame;

  assign frame = {{PREAMBLE{1'b1}}, 2'b01,
                  (launch_word.wr ? 2'b01 : 2'b10),
                  launch_word.phy, launch_word.regn, 2'b10,
                  (launch_word.wr ? wdata : {DATA_W{1'b1}})};

  assign mdio_out = sh_q[FRAME_LEN-1];
  assign mdio_oe  = busy && !(rd_q && (idx_q >= TA_I));
  assign done     = busy && fall && (idx_q == LAST);
  assign rdata    = rx_q;

  always_comb begin
    idx_d = idx_q;
    sh_d  = sh_q;
    rx_d  = rx_q;
    rd_d  = rd_q;
    if (launch) begin
      idx_d = '0;
      sh_d  = frame;
      rd_d  = !launch_word.wr;
    end else if (busy) begin
      if (rise && rd_q && (idx_q >= DAT_I))
        rx_d = {rx_q[DATA_W-2:0], mdio_in};
      if (fall && (idx_q != LAST)) begin
        idx_d = idx_q + 1'b1;
        sh_d  = {sh_q[FRAME_LEN-2:0], 1'b1};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      sh_q  <= '1;
      rx_q  <= '0;
      rd_q  <= 1'b0;
    end else begin
      idx_q <= idx_d;
      sh_q  <= sh_d;
      rx_q  <= rx_d;
      rd_q  <= rd_d;
    end
  end
endmodule

// File: rtl/mdio_ctl_regs.sv
module mdio_ctl_regs
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr,
  input  ctl_t              ctl_in,
  input  logic              data_wr,
  input  logic [DATA_W-1:0] data_in,
  input  logic              done,
  input  logic [DATA_W-1:0] rdata,
  output logic              launch,
  output logic              busy,
  output ctl_t              fields,
  output logic [DATA_W-1:0] data_q,
  output logic [CTL_W-1:0]  ctl_rdata
);
  ctl_t              f_q, f_d;
  logic              busy_q, busy_d;
  logic [DATA_W-1:0] dat_q, dat_d;

  assign launch = ctl_wr && ctl_in.go && !busy_q;
  assign busy   = busy_q;
  assign fields = f_q;
  assign data_q = dat_q;

  always_comb begin
    ctl_t rb;
    rb      = f_q;
    rb.go   = busy_q;
    rb.rsv  = '0;
    ctl_rdata = rb;
  end

  always_comb begin
    f_d    = f_q;
    busy_d = busy_q;
    dat_d  = dat_q;
    if (ctl_wr && !busy_q) begin
      f_d    = ctl_in;
      f_d.go = 1'b0;
      busy_d = ctl_in.go;
    end
    if (done)
      busy_d = 1'b0;
    if (data_wr && !busy_q)
      dat_d = data_in;
    else if (done && !f_q.wr)
      dat_d = rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      f_q    <= '0;
      busy_q <= 1'b0;
      dat_q  <= '0;
    end else begin
      f_q    <= f_d;
      busy_q <= busy_d;
      dat_q  <= dat_d;
    end
  end

  p_launch_sets_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> busy_q);
  p_busy_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !done) |=> busy_q);
  p_ctl_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && ctl_wr) |=> $stable(f_q));
  p_data_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && data_wr && !done) |=> $stable(dat_q));
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
  import mdio_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  clk_div,
  input  logic              ctl_wr,
  input  logic [CTL_W-1:0]  ctl_wdata,
  output logic [CTL_W-1:0]  ctl_rdata,
  input  logic              data_wr,
  input  logic [DATA_W-1:0] data_wdata,
  output logic [DATA_W-1:0] data_rdata,
  output logic              mdc,
  output logic              mdio_out,
  output logic              mdio_oe,
  input  logic              mdio_in
);
  logic [1:0]        rs_q;
  logic              rst_sn;
  logic              launch, busy, done, rise, fall, run;
  ctl_t              fields;
  logic [DATA_W-1:0] rdata;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sn = rs_q[1];

  assign run = busy && fields.cken;

  mdio_ctl_regs u_regs (
    .clk(clk), .rst_n(rst_sn),
    .ctl_wr(ctl_wr), .ctl_in(ctl_t'(ctl_wdata)),
    .data_wr(data_wr), .data_in(data_wdata),
    .done(done), .rdata(rdata),
    .launch(launch), .busy(busy), .fields(fields),
    .data_q(data_rdata), .ctl_rdata(ctl_rdata)
  );

  mdio_clk_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_sn), .run(run), .div(clk_div),
    .mdc(mdc), .rise(rise), .fall(fall)
  );

  mdio_frame_seq u_seq (
    .clk(clk), .rst_n(rst_sn),
    .launch(launch), .launch_word(ctl_t'(ctl_wdata)), .wdata(data_rdata),
    .busy(busy), .rise(rise), .fall(fall), .mdio_in(mdio_in),
    .mdio_out(mdio_out), .mdio_oe(mdio_oe), .done(done), .rdata(rdata)
  );

  p_mdio_moves_on_fall_r6: assert property (@(posedge clk) disable iff (!rst_sn)
    (busy && $past(busy) && !$stable(mdio_out)) |-> $fell(mdc));
  p_busy_ends_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_sn)
    $fell(busy) |-> $fell(mdc));
  p_mdc_gated_r7: assert property (@(posedge clk) disable iff (!rst_sn)
    (busy && !fields.cken) |=> !mdc);
endmodule

// File: tb/mdio_mgmt_ctrl_test.sv
module mdio_mgmt_ctrl_test;
  logic        clk, rst_n;
  logic [7:0]  clk_div;
  logic        ctl_wr, data_wr, mdio_in;
  logic [15:0] ctl_wdata, data_wdata, ctl_rdata, data_rdata;
  logic        mdc, mdio_out, mdio_oe;

  mdio_mgmt_ctrl #(.DIV_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .clk_div(clk_div),
    .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
    .data_wr(data_wr), .data_wdata(data_wdata), .data_rdata(data_rdata),
    .mdc(mdc), .mdio_out(mdio_out), .mdio_oe(mdio_oe), .mdio_in(mdio_in)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct { logic oe; logic val; int idx; } exp_t;
  exp_t exp_q[$];

  int vectors = 0, fails = 0;
  int cyc = 0, rises = 0, last_rise = 0;
  logic prev_mdc = 1'b0;
  logic phy_read = 1'b0;
  logic [15:0] phy_val = 16'h0;

  task automatic check(input logic ok, input string req, input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: compares MDIO at each MDC rise against the scoreboard, plays the PHY
  always @(negedge clk) begin
    cyc++;
    if (mdc && !prev_mdc) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R4/R5 unexpected MDC rise", rises, -1);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(mdio_oe == e.oe, "R4/R5 output enable", mdio_oe, e.oe);
        if (e.oe) check(mdio_out == e.val, "R4/R5 frame bit", mdio_out, e.val);
      end
      if (rises > 0)
        check(cyc - last_rise == 2 * (int'(clk_div) + 1), "R6 MDC period",
              cyc - last_rise, 2 * (int'(clk_div) + 1));
      last_rise = cyc;
      rises++;
    end
    if (!mdc && prev_mdc) begin
      if (phy_read && rises >= 48 && rises < 64) mdio_in = phy_val[63 - rises];
      else mdio_in = 1'b1;
    end
    prev_mdc = mdc;
  end

  task automatic do_reset();
    rst_n = 1'b0; ctl_wr = 1'b0; data_wr = 1'b0; mdio_in = 1'b1;
    ctl_wdata = '0; data_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    exp_q.delete();
  endtask

  function automatic logic [15:0] cword(logic cken, logic go, logic wr, logic [4:0] phy, logic [4:0] regn);
    return {cken, go, wr, phy, 3'b000, regn};
  endfunction

  task automatic run_txn(input logic wr, input logic [4:0] phy, input logic [4:0] regn,
                         input logic [15:0] wval, input logic [15:0] pval,
                         input logic [7:0] div, input logic interfere);
    logic [63:0] fr;
    int n;
    clk_div = div;
    @(negedge clk); data_wr = 1'b1; data_wdata = wval;
    @(negedge clk); data_wr = 1'b0;
    fr = {32'hFFFF_FFFF, 2'b01, (wr ? 2'b01 : 2'b10), phy, regn, 2'b10, wval};
    for (int i = 0; i < 64; i++) begin
      exp_t e;
      e.idx = i;
      e.oe  = wr || (i < 46);
      e.val = fr[63 - i];
      exp_q.push_back(e);
    end
    phy_read = !wr; phy_val = pval; rises = 0;
    ctl_wr = 1'b1; ctl_wdata = cword(1'b1, 1'b1, wr, phy, regn);
    @(negedge clk); ctl_wr = 1'b0;
    n = 0;
    while (ctl_rdata[14]) begin
      n++;
      if (interfere && n == 20) begin
        ctl_wr = 1'b1; ctl_wdata = cword(1'b1, 1'b1, !wr, ~phy, ~regn);
      end else if (interfere && n == 21) begin
        ctl_wr = 1'b0; data_wr = 1'b1; data_wdata = ~wval;
      end else begin
        ctl_wr = 1'b0; data_wr = 1'b0;
      end
      @(negedge clk);
    end
    data_wr = 1'b0;
    check(n == 128 * (int'(div) + 1), "R3 busy duration", n, 128 * (int'(div) + 1));
    check(rises == 64 && exp_q.size() == 0, "R4/R5 frame length", rises, 64);
    check(ctl_rdata == cword(1'b1, 1'b0, wr, phy, regn), "R2/R8 control readback",
          ctl_rdata, cword(1'b1, 1'b0, wr, phy, regn));
    if (wr) check(data_rdata == wval, "R9 data kept after write", data_rdata, wval);
    else    check(data_rdata == pval, "R5 read data captured", data_rdata, pval);
    exp_q.delete();
    phy_read = 1'b0;
  endtask

  initial begin
    clk_div = 8'd0;
    do_reset();
    // R1
    check(ctl_rdata == 16'h0, "R1 control reset", ctl_rdata, 0);
    check(data_rdata == 16'h0, "R1 data reset", data_rdata, 0);
    check(!mdc && !mdio_oe, "R1 mdc/oe reset", {mdc, mdio_oe}, 0);

    // R10: fields only
    @(negedge clk); ctl_wr = 1'b1; ctl_wdata = cword(1'b1, 1'b0, 1'b1, 5'h0A, 5'h15) | 16'h00E0;
    @(negedge clk); ctl_wr = 1'b0;
    check(ctl_rdata == cword(1'b1, 1'b0, 1'b1, 5'h0A, 5'h15), "R10 fields stored, R2 rsv zero",
          ctl_rdata, cword(1'b1, 1'b0, 1'b1, 5'h0A, 5'h15));
    rises = 0;
    repeat (50) @(negedge clk);
    check(rises == 0 && !ctl_rdata[14], "R10 no transaction started", rises, 0);

    // R4 write, R5 read, R6 period, divider variants
    run_txn(1'b1, 5'h01, 5'h00, 16'h8000, 16'h0000, 8'd0, 1'b0);
    run_txn(1'b0, 5'h11, 5'h02, 16'h0000, 16'hA5C3, 8'd1, 1'b0);
    run_txn(1'b1, 5'h1F, 5'h1F, 16'h3C5A, 16'h0000, 8'd3, 1'b0);
    run_txn(1'b0, 5'h00, 5'h1F, 16'h1234, 16'h0001, 8'd0, 1'b0);
    // R8/R9: writes while busy
    run_txn(1'b1, 5'h05, 5'h09, 16'hBEEF, 16'h0000, 8'd1, 1'b1);
    run_txn(1'b0, 5'h12, 5'h04, 16'h5555, 16'hF00D, 8'd2, 1'b1);

    // R7: launch with MDC enable clear
    rises = 0;
    @(negedge clk); ctl_wr = 1'b1; ctl_wdata = cword(1'b0, 1'b1, 1'b1, 5'h03, 5'h03);
    @(negedge clk); ctl_wr = 1'b0;
    repeat (300) @(negedge clk);
    check(rises == 0 && !mdc, "R7 MDC held low", rises, 0);
    check(ctl_rdata[14] == 1'b1, "R7 busy stays set", ctl_rdata[14], 1);
    do_reset();
    check(ctl_rdata == 16'h0 && !mdc, "R1 reset after stall", ctl_rdata, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule